// File: doc/BRIEF.md
# Block Transfer and Search Sequencer

This block carries out the processor's string-style instructions one byte at a time: copying memory to memory, scanning memory for a byte equal to the accumulator, and moving bytes between an I/O port and memory. It starts from a decoded operation code, a direction bit and a repeat bit, together with the current pointer pair (HL as source or buffer pointer, DE as destination pointer), the 16-bit count BC and the accumulator. It drives a memory port and an I/O port, and returns the updated pointers, count and flags.

Every step takes two cycles. In the first cycle a read strobe is issued. In the second cycle the returned byte is written, compared or sent, and the pointers and counter are updated. With the repeat bit clear, the block performs one step. With the repeat bit set, it keeps stepping until the count runs out. A search also stops on the first byte that matches. Both memory and I/O read data are expected one cycle after the read strobe.

Top module: `blk_seq`

## Requirements
- R1: After reset, busy, done, all four strobes, the pointer, count and flag outputs are all zero.
- R2: Operation code 2'b00 (copy) reads memory at HL and writes that byte to memory at DE.
- R3: Direction bit 0 adds one to the stepped pointers after each step, and direction bit 1 subtracts one.
- R4: A copy step moves HL and DE, lowers BC by one, clears H and N, and sets PV exactly when the new BC is non-zero.
- R5: Operation code 2'b01 (compare) reads memory at HL and never writes. Z is set when the accumulator equals the byte, N is set, HL steps, BC drops by one, and PV reflects a non-zero new BC.
- R6: Operation code 2'b10 (input) reads the port at the full BC address, using B before its decrement. It stores the byte in memory at HL, steps HL, and lowers only B (BC bits 15:8) by one. Z is set when the new B is zero, and N is set.
- R7: Operation code 2'b11 (output) reads memory at HL and writes the byte to the port at the full BC address, using B before its decrement. The pointer, B and the flags are updated as in R6.
- R8: With the repeat bit set, steps continue until BC reaches zero for copy and compare, or until B reaches zero for input and output.
- R9: A repeating compare ends after the first step whose byte equals the accumulator. The returned pointers and count are those after that step.
- R10: busy is high from the cycle after an accepted start until the last step ends. done is high for exactly one cycle: the first cycle with busy low.
- R11: A start while busy is ignored. Outside a run, no strobe is asserted.
- R12: Each step is a read-strobe cycle followed by a write/evaluate cycle. A run of N steps ends with done visible 2N+1 cycles after start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | 00 copy, 01 compare, 10 input, 11 output |
| dec | input | 1 | 1 = pointers step down |
| rpt | input | 1 | 1 = repeat until count ends |
| hl_in | input | 16 | Initial source/buffer pointer |
| de_in | input | 16 | Initial destination pointer |
| bc_in | input | 16 | Initial count / port address |
| acc_in | input | 8 | Accumulator for compare |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_rd |
| io_addr | output | 16 | Port address (full BC) |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data, one cycle after io_rd |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hl_out | output | 16 | Current HL |
| de_out | output | 16 | Current DE |
| bc_out | output | 16 | Current BC |
| z_flag | output | 1 | Zero flag |
| pv_flag | output | 1 | Parity/overflow flag (count non-zero) |
| h_flag | output | 1 | Half-borrow flag |
| n_flag | output | 1 | Subtract flag |

## Verification
The assertions check the cycle-level rules on every cycle: at most one strobe is active at a time, each write follows a read strobe one cycle earlier, the count drops by one (copy) or by 256 (input) after each writing step, done lasts one cycle and falls right after busy, and no strobe is active while idle. Data movement cannot be checked by assertions, so the bench scenarios cover it. These scenarios check which bytes land at which addresses, pointer direction, the exact repeat lengths, an early stop on a match, full 16-bit port addresses, and the final flag values.

// File: rtl/blk_seq.sv
module blk_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic        dec,
  input  logic        rpt,
  input  logic [15:0] hl_in,
  input  logic [15:0] de_in,
  input  logic [15:0] bc_in,
  input  logic [7:0]  acc_in,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] io_addr,
  output logic        io_rd,
  output logic        io_wr,
  output logic [7:0]  io_wdata,
  input  logic [7:0]  io_rdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] hl_out,
  output logic [15:0] de_out,
  output logic [15:0] bc_out,
  output logic        z_flag,
  output logic        pv_flag,
  output logic        h_flag,
  output logic        n_flag
);
  localparam logic [1:0] OP_COPY = 2'b00;
  localparam logic [1:0] OP_CMP  = 2'b01;
  localparam logic [1:0] OP_IN   = 2'b10;
  localparam logic [1:0] OP_OUT  = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_XFER} st_t;

  st_t         st;
  logic [1:0]  op_q;
  logic        dec_q, rpt_q, done_q;
  logic [15:0] hl, de, bc;
  logic [7:0]  acc;
  logic        z, pv, h, n;

  logic        is_io, match, cnt_zero, stop;
  logic [7:0]  rd_byte;
  logic [15:0] step, hl_nx, de_nx, bc_nx;

  assign is_io    = op_q[1];
  assign rd_byte  = (op_q == OP_IN) ? io_rdata : mem_rdata;
  assign step     = dec_q ? 16'hFFFF : 16'h0001;
  assign hl_nx    = hl + step;
  assign de_nx    = de + step;
  assign bc_nx    = is_io ? {bc[15:8] - 8'd1, bc[7:0]} : bc - 16'd1;
  assign cnt_zero = is_io ? (bc_nx[15:8] == 8'd0) : (bc_nx == 16'd0);
  assign match    = (acc == rd_byte);
  assign stop     = !rpt_q || cnt_zero || (op_q == OP_CMP && match);

  assign mem_rd    = (st == S_READ) && (op_q != OP_IN);
  assign io_rd     = (st == S_READ) && (op_q == OP_IN);
  assign mem_wr    = (st == S_XFER) && (op_q == OP_COPY || op_q == OP_IN);
  assign io_wr     = (st == S_XFER) && (op_q == OP_OUT);
  assign mem_addr  = (st == S_XFER && op_q == OP_COPY) ? de : hl;
  assign mem_wdata = rd_byte;
  assign io_addr   = bc;
  assign io_wdata  = mem_rdata;

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign hl_out  = hl;
  assign de_out  = de;
  assign bc_out  = bc;
  assign z_flag  = z;
  assign pv_flag = pv;
  assign h_flag  = h;
  assign n_flag  = n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_COPY;
      dec_q  <= 1'b0;
      rpt_q  <= 1'b0;
      done_q <= 1'b0;
      hl     <= '0;
      de     <= '0;
      bc     <= '0;
      acc    <= '0;
      z      <= 1'b0;
      pv     <= 1'b0;
      h      <= 1'b0;
      n      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q  <= op;
          dec_q <= dec;
          rpt_q <= rpt;
          hl    <= hl_in;
          de    <= de_in;
          bc    <= bc_in;
          acc   <= acc_in;
          st    <= S_READ;
        end
        S_READ: st <= S_XFER;
        S_XFER: begin
          hl <= hl_nx;
          bc <= bc_nx;
          case (op_q)
            OP_COPY: begin
              de <= de_nx;
              h  <= 1'b0;
              n  <= 1'b0;
              pv <= (bc_nx != 16'd0);
            end
            OP_CMP: begin
              z  <= match;
              n  <= 1'b1;
              h  <= (acc[3:0] < rd_byte[3:0]);
              pv <= (bc_nx != 16'd0);
            end
            default: begin
              z <= (bc_nx[15:8] == 8'd0);
              n <= 1'b1;
            end
          endcase
          if (stop) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= S_READ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_seq_chk.sv
module blk_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        io_rd,
  input logic        io_wr,
  input logic        busy,
  input logic        done,
  input logic [15:0] bc_out
);
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1);

  a_r12_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || io_wr) |-> $past(mem_rd || io_rd));

  a_r4_bc_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_rd) && mem_wr) |=> (bc_out == $past(bc_out) - 16'd1));

  a_r6_b_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(io_rd) && mem_wr) |=> (bc_out == $past(bc_out) - 16'h0100));

  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd || mem_wr || io_rd || io_wr));
endmodule

bind blk_seq blk_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .io_wr(io_wr), .busy(busy), .done(done), .bc_out(bc_out)
);

// File: tb/test_blk_seq.sv
module test_blk_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic dec = 1'b0, rpt = 1'b0;
  logic [15:0] hl_in = '0, de_in = '0, bc_in = '0;
  logic [7:0] acc_in = '0;
  logic [15:0] mem_addr, io_addr, hl_out, de_out, bc_out;
  logic mem_rd, mem_wr, io_rd, io_wr, busy, done, z_flag, pv_flag, h_flag, n_flag;
  logic [7:0] mem_wdata, io_wdata;
  logic [7:0] mem_rdata = '0, io_rdata = '0;

  logic [7:0]  mem [256];
  logic [15:0] log_a [8];
  logic [7:0]  log_d [8];
  int log_n = 0;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  blk_seq i_blk_seq (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= i[7:0] ^ 8'h3C;
    end else if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr[7:0]];
    io_rdata  <= io_addr[7:0] ^ io_addr[15:8] ^ 8'h5A;
    if (!rst_n) log_n <= 0;
    else if (io_wr) begin
      log_a[log_n[2:0]] <= io_addr;
      log_d[log_n[2:0]] <= io_wdata;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic d, input logic r,
                     input logic [15:0] hl, input logic [15:0] de,
                     input logic [15:0] bc, input logic [7:0] a, output int cyc);
    @(negedge clk);
    op = o; dec = d; rpt = r; hl_in = hl; de_in = de; bc_in = bc; acc_in = a;
    start = 1'b1;
    cyc = 0;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk("R10 busy after start", busy, 1);
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R10 busy low with done", busy, 0);
    @(negedge clk);
    chk("R10 done single cycle", done, 0);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 strobes", {mem_rd, mem_wr, io_rd, io_wr}, 0);
    chk("R1 regs", {hl_out, bc_out}, 0);
    chk("R1 de", de_out, 0);
    chk("R1 flags", {z_flag, pv_flag, h_flag, n_flag}, 0);
  endtask

  task automatic t_copy_single;
    int c;
    run(2'b00, 0, 0, 16'h0010, 16'h0040, 16'h0003, 8'h00, c);
    chk("R2 copied byte", mem[8'h40], 8'h2C);
    chk("R3 hl up", hl_out, 16'h0011);
    chk("R3 de up", de_out, 16'h0041);
    chk("R4 bc", bc_out, 16'h0002);
    chk("R4 pv set", pv_flag, 1);
    chk("R4 h n clear", {h_flag, n_flag}, 0);
    chk("R12 cycles single", c, 3);
  endtask

  task automatic t_copy_down_rpt;
    int c;
    run(2'b00, 1, 1, 16'h0022, 16'h0082, 16'h0003, 8'h00, c);
    chk("R2 byte 82", mem[8'h82], 8'h1E);
    chk("R2 byte 81", mem[8'h81], 8'h1D);
    chk("R2 byte 80", mem[8'h80], 8'h1C);
    chk("R3 hl down", hl_out, 16'h001F);
    chk("R3 de down", de_out, 16'h007F);
    chk("R8 bc zero", bc_out, 16'h0000);
    chk("R4 pv clear", pv_flag, 0);
    chk("R12 cycles 3 steps", c, 7);
  endtask

  task automatic t_copy_last;
    int c;
    run(2'b00, 0, 0, 16'h0005, 16'h00A0, 16'h0001, 8'h00, c);
    chk("R2 byte A0", mem[8'hA0], 8'h39);
    chk("R4 bc to zero", bc_out, 16'h0000);
    chk("R4 pv clear at zero", pv_flag, 0);
  endtask

  task automatic t_cmp_match;
    int c;
    run(2'b01, 0, 1, 16'h0030, 16'h0090, 16'h0008, 8'h0E, c);
    chk("R9 hl at match", hl_out, 16'h0033);
    chk("R9 bc at match", bc_out, 16'h0005);
    chk("R5 z set", z_flag, 1);
    chk("R5 n set", n_flag, 1);
    chk("R5 pv set", pv_flag, 1);
    chk("R5 no write", mem[8'h90], 8'hAC);
    chk("R5 de untouched", de_out, 16'h0090);
    chk("R9 cycles", c, 7);
  endtask

  task automatic t_cmp_nomatch;
    int c;
    run(2'b01, 0, 1, 16'h0030, 16'h0090, 16'h0002, 8'h99, c);
    chk("R8 cmp hl", hl_out, 16'h0032);
    chk("R8 cmp bc", bc_out, 16'h0000);
    chk("R5 z clear", z_flag, 0);
    chk("R5 pv clear", pv_flag, 0);
    chk("R12 cycles 2 steps", c, 5);
  endtask

  task automatic t_in_single;
    int c;
    run(2'b10, 0, 0, 16'h0050, 16'h0000, 16'h0312, 8'h00, c);
    chk("R6 stored port byte", mem[8'h50], 8'h4B);
    chk("R6 hl up", hl_out, 16'h0051);
    chk("R6 only B drops", bc_out, 16'h0212);
    chk("R6 z clear n set", {z_flag, n_flag}, 2'b01);
    chk("R12 cycles io", c, 3);
  endtask

  task automatic t_in_down_rpt;
    int c;
    run(2'b10, 1, 1, 16'h0062, 16'h0000, 16'h0207, 8'h00, c);
    chk("R6 port 0207 byte", mem[8'h62], 8'h5F);
    chk("R6 port 0107 byte", mem[8'h61], 8'h5C);
    chk("R3 hl down io", hl_out, 16'h0060);
    chk("R8 B zero", bc_out, 16'h0007);
    chk("R6 z set", z_flag, 1);
    chk("R12 cycles io rpt", c, 5);
  endtask

  task automatic t_out_rpt;
    int c, base;
    base = log_n;
    run(2'b11, 0, 1, 16'h0070, 16'h0000, 16'h0244, 8'h00, c);
    chk("R7 write count", log_n - base, 2);
    chk("R7 addr 1", log_a[base[2:0]], 16'h0244);
    chk("R7 data 1", log_d[base[2:0]], 8'h4C);
    chk("R7 addr 2", log_a[base[2:0] + 3'd1], 16'h0144);
    chk("R7 data 2", log_d[base[2:0] + 3'd1], 8'h4D);
    chk("R7 hl", hl_out, 16'h0072);
    chk("R8 B zero out", bc_out, 16'h0044);
    chk("R7 z", z_flag, 1);
  endtask

  task automatic t_start_busy;
    int c;
    @(negedge clk);
    op = 2'b00; dec = 0; rpt = 0; hl_in = 16'h00B0; de_in = 16'h00C0; bc_in = 16'h0002;
    start = 1'b1;
    @(negedge clk);
    op = 2'b10; hl_in = 16'h00D0; bc_in = 16'h0505;
    @(negedge clk);
    start = 1'b0;
    c = 0;
    while (!done && c < 100) begin @(negedge clk); c++; end
    chk("R11 first run result", {hl_out, de_out}, {16'h00B1, 16'h00C1});
    chk("R11 bc first run", bc_out, 16'h0001);
    chk("R11 copied byte", mem[8'hC0], 8'h8C);
    chk("R11 no second run", mem[8'hD0], 8'hEC);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 stays idle", {busy, mem_rd, mem_wr, io_rd, io_wr}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy_single();
    t_copy_down_rpt();
    t_copy_last();
    t_cmp_match();
    t_cmp_nomatch();
    t_in_single();
    t_in_down_rpt();
    t_out_rpt();
    t_start_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule